// File: doc/BRIEF.md
# Sign-Steered Cross-Correlation Accumulator

This unit keeps an 8x8 matrix of 8-bit cross-correlation sums between a vector of antipodal bits (each one standing for +1 or -1) and a vector of eight signed 8-bit integers. The integer vector sits in a 64-bit operand register as eight lanes. The bit vector sits in an 8-bit sign register. The matrix is held as eight 64-bit accumulator rows.

A single update strobe folds one product term into every entry of the matrix in one clock. Row i adds the operand lanes when its sign bit is 1 and subtracts them when the bit is 0. Because every bit is plus or minus one, the unit needs no multiplier.

Software-visible framing is out of scope. The surrounding datapath loads the operand and sign registers, pulses the strobe once per sample, and reads results back one row at a time through a row-select port.

Top module: `xcorr_sign_acc`

## Requirements
- R1: When `opnd_ld` is high at a clock edge, the operand register takes `opnd_din`. When `sign_ld` is high, the sign register takes `sign_din`. When a load enable is low, its register keeps its value.
- R2: On an update, each row whose sign bit is 1 adds operand lane j to its own lane j. Sign bit i (bit i of the sign register) steers row i. Lane j occupies bits 8j+7 to 8j of both the operand and the row.
- R3: On an update, each row whose sign bit is 0 subtracts operand lane j from its own lane j.
- R4: Each lane wraps modulo 256, and no carry or borrow passes into a neighbouring lane.
- R5: All eight rows take their update in the same clock edge in which `upd` is sampled high.
- R6: When `clr` is high at a clock edge, all 64 lanes become zero, even if `upd` is high in the same cycle.
- R7: Without `upd` or `clr`, the accumulators hold their values, including while new operands or signs are loaded.
- R8: An update in the same cycle as a load uses the operand and sign values held before that edge. The newly loaded values first take effect on the next update.
- R9: `rd_row` shows, without a clock delay, the accumulator row whose index is on `rd_sel` (0 to 7).
- R10: After reset, all accumulators, the operand register and the sign register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| opnd_ld | input | 1 | Load enable for the operand register |
| opnd_din | input | 64 | Eight 8-bit integer lanes to load |
| sign_ld | input | 1 | Load enable for the sign register |
| sign_din | input | 8 | Sign bits, 1 means +1 and 0 means -1 |
| upd | input | 1 | Update strobe applying one accumulation to all rows |
| clr | input | 1 | Synchronous clear of all accumulators |
| rd_sel | input | 3 | Row index to read |
| rd_row | output | 64 | Selected accumulator row |

## Verification
Two pairs of functions can land in the same cycle. Clear can meet update, and clear must win. A register load can meet update, and the update must use the old operand and sign values. The bench provokes both pairs by raising the strobes together on one edge. It then reads all eight rows and compares them with a reference matrix. That reference applies the clear first, then the update with the previous operands, and then the load. A wrong priority or a wrong operand choice shows up as a mismatched lane on the following reads.

// File: rtl/xcorr_pkg.sv
`timescale 1ns/1ps
package xcorr_pkg;
  parameter int unsigned LANES  = 8;
  parameter int unsigned LANE_W = 8;
  parameter int unsigned ROWS   = 8;
  localparam int unsigned ROW_W = LANES * LANE_W;
  localparam int unsigned SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1;
endpackage

// File: rtl/xc_rst_sync.sv
`timescale 1ns/1ps
module xc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/xc_opnd_regs.sv
`timescale 1ns/1ps
module xc_opnd_regs #(
  parameter int unsigned ROW_W = xcorr_pkg::ROW_W,
  parameter int unsigned ROWS  = xcorr_pkg::ROWS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opnd_ld,
  input  logic [ROW_W-1:0] opnd_din,
  input  logic             sign_ld,
  input  logic [ROWS-1:0]  sign_din,
  output logic [ROW_W-1:0] opnd_q,
  output logic [ROWS-1:0]  sign_q
);
  logic [ROW_W-1:0] opnd_d;
  logic [ROWS-1:0]  sign_d;

  always_comb begin
    opnd_d = opnd_q;
    sign_d = sign_q;
    if (opnd_ld) opnd_d = opnd_din;
    if (sign_ld) sign_d = sign_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      sign_q <= '0;
    end else begin
      opnd_q <= opnd_d;
      sign_q <= sign_d;
    end
  end

  AST_OPND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_ld |=> opnd_q == $past(opnd_din)); // R1
  AST_OPND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !opnd_ld |=> $stable(opnd_q)); // R1
  AST_SIGN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sign_ld |=> sign_q == $past(sign_din)); // R1
endmodule

// File: rtl/xc_row_addsub.sv
`timescale 1ns/1ps
module xc_row_addsub #(
  parameter int unsigned LANES  = xcorr_pkg::LANES,
  parameter int unsigned LANE_W = xcorr_pkg::LANE_W,
  localparam int unsigned ROW_W = LANES * LANE_W
) (
  input  logic [ROW_W-1:0] acc_row,
  input  logic [ROW_W-1:0] opnd,
  input  logic             add_sel,
  output logic [ROW_W-1:0] row_next
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] a_lane;
    logic [LANE_W-1:0] b_lane;
    assign a_lane = acc_row[l*LANE_W +: LANE_W];
    assign b_lane = opnd[l*LANE_W +: LANE_W];
    assign row_next[l*LANE_W +: LANE_W] = add_sel ? (a_lane + b_lane) : (a_lane - b_lane);
  end
endmodule

// File: rtl/xc_acc_bank.sv
`timescale 1ns/1ps
module xc_acc_bank #(
  parameter int unsigned LANES  = xcorr_pkg::LANES,
  parameter int unsigned LANE_W = xcorr_pkg::LANE_W,
  parameter int unsigned ROWS   = xcorr_pkg::ROWS,
  localparam int unsigned ROW_W = LANES * LANE_W,
  localparam int unsigned SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             clr,
  input  logic [ROW_W-1:0] opnd,
  input  logic [ROWS-1:0]  sign,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ROW_W-1:0] rd_row
);
  logic [ROW_W-1:0] acc_q   [ROWS];
  logic [ROW_W-1:0] acc_sum [ROWS];
  logic [ROW_W-1:0] acc_d   [ROWS];
  logic             acc_en;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    xc_row_addsub #(.LANES(LANES), .LANE_W(LANE_W)) u_addsub (
      .acc_row  (acc_q[r]),
      .opnd     (opnd),
      .add_sel  (sign[r]),
      .row_next (acc_sum[r])
    );
  end

  assign acc_en = upd | clr;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      if (clr) acc_d[r] = '0;
      else     acc_d[r] = acc_sum[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) acc_q[r] <= '0;
    end else if (acc_en) begin
      for (int r = 0; r < ROWS; r++) acc_q[r] <= acc_d[r];
    end
  end

  assign rd_row = acc_q[rd_sel];

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_q[r] == '0); // R6
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !clr) |=> $stable(acc_q[r])); // R7
    for (genvar l = 0; l < LANES; l++) begin : g_lchk
      AST_LANE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && sign[r]) |=> acc_q[r][l*LANE_W +: LANE_W] ==
          LANE_W'($past(acc_q[r][l*LANE_W +: LANE_W]) + $past(opnd[l*LANE_W +: LANE_W]))); // R2
      AST_LANE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && !sign[r]) |=> acc_q[r][l*LANE_W +: LANE_W] ==
          LANE_W'($past(acc_q[r][l*LANE_W +: LANE_W]) - $past(opnd[l*LANE_W +: LANE_W]))); // R3
    end
  end
endmodule

// File: rtl/xcorr_sign_acc.sv
`timescale 1ns/1ps
module xcorr_sign_acc #(
  parameter int unsigned LANES  = xcorr_pkg::LANES,
  parameter int unsigned LANE_W = xcorr_pkg::LANE_W,
  parameter int unsigned ROWS   = xcorr_pkg::ROWS,
  localparam int unsigned ROW_W = LANES * LANE_W,
  localparam int unsigned SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opnd_ld,
  input  logic [ROW_W-1:0] opnd_din,
  input  logic             sign_ld,
  input  logic [ROWS-1:0]  sign_din,
  input  logic             upd,
  input  logic             clr,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ROW_W-1:0] rd_row
);
  logic             rst_n_s;
  logic [ROW_W-1:0] opnd_q;
  logic [ROWS-1:0]  sign_q;

  xc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  xc_opnd_regs #(.ROW_W(ROW_W), .ROWS(ROWS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .opnd_ld  (opnd_ld),
    .opnd_din (opnd_din),
    .sign_ld  (sign_ld),
    .sign_din (sign_din),
    .opnd_q   (opnd_q),
    .sign_q   (sign_q)
  );

  xc_acc_bank #(.LANES(LANES), .LANE_W(LANE_W), .ROWS(ROWS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .upd    (upd),
    .clr    (clr),
    .opnd   (opnd_q),
    .sign   (sign_q),
    .rd_sel (rd_sel),
    .rd_row (rd_row)
  );
endmodule

// File: tb/xcorr_sign_acc_tb.sv
`timescale 1ns/1ps
module xcorr_sign_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opnd_ld = 1'b0;
  logic [63:0] opnd_din = '0;
  logic        sign_ld = 1'b0;
  logic [7:0]  sign_din = '0;
  logic        upd = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_row;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  m_acc [8][8];
  logic [63:0] m_opnd = '0;
  logic [7:0]  m_sign = '0;

  always #2 clk = ~clk;

  xcorr_sign_acc dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_ld(opnd_ld), .opnd_din(opnd_din),
    .sign_ld(sign_ld), .sign_din(sign_din), .upd(upd), .clr(clr),
    .rd_sel(rd_sel), .rd_row(rd_row)
  );

  function automatic logic [63:0] model_row(int r);
    logic [63:0] v;
    for (int l = 0; l < 8; l++) v[l*8 +: 8] = m_acc[r][l];
    return v;
  endfunction

  task automatic check_rows(string tag);
    for (int r = 0; r < 8; r++) begin
      rd_sel = 3'(r);
      #0.5;
      checks++;
      if (rd_row !== model_row(r)) begin
        errors++;
        $display("FAIL %s row %0d: actual %h expected %h", tag, r, rd_row, model_row(r));
      end
    end
  endtask

  // one clock of stimulus, with the reference updated in edge order
  task automatic step(bit u, bit c, bit lo, logic [63:0] od, bit ls, logic [7:0] sd);
    @(negedge clk);
    upd = u; clr = c; opnd_ld = lo; opnd_din = od; sign_ld = ls; sign_din = sd;
    @(negedge clk);
    upd = 0; clr = 0; opnd_ld = 0; sign_ld = 0;
    for (int r = 0; r < 8; r++)
      for (int l = 0; l < 8; l++) begin
        if (c) m_acc[r][l] = 8'h00;
        else if (u) m_acc[r][l] = m_sign[r] ? m_acc[r][l] + m_opnd[l*8 +: 8]
                                            : m_acc[r][l] - m_opnd[l*8 +: 8];
      end
    if (lo) m_opnd = od;
    if (ls) m_sign = sd;
  endtask

  task automatic t_reset;
    for (int r = 0; r < 8; r++) for (int l = 0; l < 8; l++) m_acc[r][l] = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_rows("R10 reset rows");
    step(1, 0, 0, '0, 0, '0);
    check_rows("R10 reset operands zero");
  endtask

  task automatic t_add_sub;
    step(0, 0, 1, 64'h0807_0605_0403_0201, 1, 8'hFF);
    check_rows("R7 load without update");
    step(1, 0, 0, '0, 0, '0);
    check_rows("R2 R5 add all rows");
    step(0, 0, 0, '0, 1, 8'h00);
    step(1, 0, 0, '0, 0, '0);
    check_rows("R3 subtract all rows");
    step(0, 0, 0, '0, 1, 8'hA5);
    step(1, 0, 0, '0, 0, '0);
    check_rows("R2 R3 mixed signs");
    rd_sel = 3'd7; #0.5;
    checks++;
    if (rd_row[7:0] !== m_acc[7][0]) begin
      errors++;
      $display("FAIL R9 direct read: actual %h expected %h", rd_row[7:0], m_acc[7][0]);
    end
  endtask

  task automatic t_wrap;
    step(1, 1, 1, 64'hFF7F_01FF_807F_FF01, 1, 8'h0F);
    step(1, 0, 0, '0, 0, '0);
    step(1, 0, 1, 64'h0101_FF01_0101_0101, 0, '0);
    step(1, 0, 0, '0, 0, '0);
    check_rows("R4 lane wrap no carry");
  endtask

  task automatic t_clear_vs_update;
    step(0, 0, 1, 64'h1122_3344_5566_7788, 1, 8'h3C);
    step(1, 0, 0, '0, 0, '0);
    step(1, 1, 0, '0, 0, '0);
    check_rows("R6 clear beats update");
    step(1, 0, 0, '0, 0, '0);
    check_rows("R6 update after clear");
  endtask

  task automatic t_load_with_update;
    step(1, 0, 1, 64'h9090_9090_0A0A_0A0A, 1, 8'hC3);
    check_rows("R8 update uses old operands");
    step(1, 0, 0, '0, 0, '0);
    check_rows("R8 new operands next update");
  endtask

  task automatic t_hold;
    step(0, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 1, 8'h5A);
    step(0, 0, 0, '0, 0, '0);
    check_rows("R7 hold without strobe");
  endtask

  task automatic t_random;
    for (int k = 0; k < 40; k++) begin
      step(($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 2) == 1,
           {$urandom, $urandom}, ($urandom % 2) == 1, 8'($urandom));
    end
    check_rows("R2 R3 R4 random accumulation");
  endtask

  initial begin
    t_reset;
    t_add_sub;
    t_wrap;
    t_clear_vs_update;
    t_load_with_update;
    t_hold;
    t_random;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule